// File: doc/BRIEF.md
# SPI Interrupt Status Unit

This block gathers the interrupt conditions of an SPI master into one seven-bit status word. It compares the transmit and receive FIFO fill levels against programmable thresholds, latches a mode-fault pulse, and drives a single registered interrupt line. The FIFOs and the serial shifter live elsewhere. This unit sees only their fill levels and the fault pulse.

Software reaches the unit through a simple word-addressed register port. Status bits are cleared by writing ones to them. The interrupt mask cannot be written directly. Ones written to the enable register set mask bits, ones written to the disable register clear them, and the mask itself can only be read. Bits 0 and 6 exist in the mask but no condition drives them, so they always read 0 in the status word.

The design has no state machine. It is built from three register groups (control, status, interrupt output), each with its own sequential process.

Top module: `spi_irq_status`

## Requirements
- R1: After reset the status reads 0x00, the mask reads 0x00, the interrupt output is 0, the transmit threshold is 1 and the receive threshold is 32.
- R2: A write to offset 0x08 sets every mask bit written as 1 and leaves bits written as 0 unchanged. The change appears at the clock edge of the write.
- R3: A write to offset 0x0C clears every mask bit written as 1 and leaves bits written as 0 unchanged. Writing 0x7F masks all seven bits.
- R4: The mask reads back at offset 0x10. A write to 0x10 does not change it.
- R5: Status bit 2 is set at a clock edge where the transmit level is below the transmit threshold (with a threshold of 1, this means the FIFO is empty). Once set, it stays set until a 1 is written to bit 2 at offset 0x04. If the condition still holds on that edge, the bit stays set.
- R6: Status bit 4 shows, one edge late, whether the receive level is nonzero. Writing a 1 to it has no lasting effect, and it clears only when the level reaches 0.
- R7: Status bit 5 is set when the receive level is at or above the receive threshold. It stays set until cleared by a write of 1, and is set again if the condition still holds.
- R8: Status bit 3 is set when the transmit level equals the FIFO depth (63). It stays set until cleared by a write of 1.
- R9: A one-cycle mode-fault pulse sets status bit 1, which then stays set until cleared by a write of 1. A pulse on the same edge as the clearing write wins, and the bit stays set.
- R10: The interrupt output is 1 exactly one clock after a cycle in which some status bit and its mask bit are both 1.
- R11: The thresholds are written at offsets 0x28 (transmit) and 0x2C (receive) and read back there. Status bits 0 and 6 always read 0, even after a write of ones.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Register write strobe |
| addr | input | 8 | Byte offset of the register |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for `addr`, combinational |
| tx_level | input | 6 | Transmit FIFO fill level |
| rx_level | input | 6 | Receive FIFO fill level |
| mode_fault | input | 1 | Mode-fault pulse |
| irq | output | 1 | Registered interrupt request |

## Verification
The bench drives each status condition in several ways and checks that the three bit behaviours can be told apart:
- Sticky threshold bits are held high after their condition goes away, then cleared by a write, then set again when the write lands while the condition still holds.
- The receive-not-empty bit is driven the same way, and must ignore the clearing write and follow only the drain.
- The thresholds are moved away from their reset values, so a wrong comparison (strict against inclusive) or a hard-wired threshold gives a different status word.
- Mask updates are tried with overlapping set, clear and direct-write patterns.
- The interrupt line is checked in the cycle before and the cycle after each mask or status change, which exposes a missing or doubled register stage.

// File: rtl/spi_irq_pkg.sv
package spi_irq_pkg;
    localparam int NBITS = 7;
    typedef logic [NBITS-1:0] irq_vec_t;

    localparam logic [7:0] OFS_STATUS  = 8'h04;
    localparam logic [7:0] OFS_ENABLE  = 8'h08;
    localparam logic [7:0] OFS_DISABLE = 8'h0C;
    localparam logic [7:0] OFS_MASK    = 8'h10;
    localparam logic [7:0] OFS_TXTHR   = 8'h28;
    localparam logic [7:0] OFS_RXTHR   = 8'h2C;

    localparam int B_FAULT  = 1;
    localparam int B_TXLOW  = 2;
    localparam int B_TXFULL = 3;
    localparam int B_RXNE   = 4;
    localparam int B_RXHIGH = 5;

    // bit behaviour: latched until written 1, or follow the condition
    localparam irq_vec_t STICKY_BITS = irq_vec_t'((1 << B_FAULT) | (1 << B_TXLOW) |
                                                  (1 << B_TXFULL) | (1 << B_RXHIGH));
    localparam irq_vec_t LEVEL_BITS  = irq_vec_t'(1 << B_RXNE);
endpackage

// File: rtl/spi_irq_regs.sv
module spi_irq_regs
    import spi_irq_pkg::*;
#(
    parameter int LVL_W      = 6,
    parameter int TX_THR_RST = 1,
    parameter int RX_THR_RST = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [7:0]       addr,
    input  logic [NBITS-1:0] wbits,
    input  logic [LVL_W-1:0] wthr,
    output irq_vec_t         mask,
    output logic [LVL_W-1:0] tx_thr,
    output logic [LVL_W-1:0] rx_thr
);
    logic en_wr, dis_wr;
    assign en_wr  = wr_en && (addr == OFS_ENABLE);
    assign dis_wr = wr_en && (addr == OFS_DISABLE);

    always_ff @(posedge clk) begin
        if (rst) begin
            mask <= '0;
        end else if (en_wr) begin
            mask <= mask | wbits;
        end else if (dis_wr) begin
            mask <= mask & ~wbits;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            tx_thr <= LVL_W'(TX_THR_RST);
            rx_thr <= LVL_W'(RX_THR_RST);
        end else if (wr_en) begin
            if (addr == OFS_TXTHR) tx_thr <= wthr;
            if (addr == OFS_RXTHR) rx_thr <= wthr;
        end
    end

    assert_en_set_R2: assert property (@(posedge clk) disable iff (rst)
        en_wr |=> ((mask & $past(wbits)) == $past(wbits)));
    assert_dis_clr_R3: assert property (@(posedge clk) disable iff (rst)
        dis_wr |=> ((mask & $past(wbits)) == '0));
    assert_mask_hold_R4: assert property (@(posedge clk) disable iff (rst)
        !(en_wr || dis_wr) |=> $stable(mask));
endmodule

// File: rtl/spi_irq_stat.sv
module spi_irq_stat
    import spi_irq_pkg::*;
#(
    parameter int FIFO_DEPTH = 63,
    parameter int LVL_W      = 6
) (
    input  logic             clk,
    input  logic             rst,
    input  irq_vec_t         clr_vec,
    input  logic [LVL_W-1:0] tx_level,
    input  logic [LVL_W-1:0] rx_level,
    input  logic [LVL_W-1:0] tx_thr,
    input  logic [LVL_W-1:0] rx_thr,
    input  logic             mode_fault,
    output irq_vec_t         status
);
    irq_vec_t cond;

    always_comb begin
        cond           = '0;
        cond[B_FAULT]  = mode_fault;
        cond[B_TXLOW]  = tx_level < tx_thr;
        cond[B_TXFULL] = tx_level == LVL_W'(FIFO_DEPTH);
        cond[B_RXNE]   = rx_level != '0;
        cond[B_RXHIGH] = rx_level >= rx_thr;
    end

    for (genvar i = 0; i < NBITS; i++) begin : g_bit
        if (STICKY_BITS[i]) begin : g_sticky
            always_ff @(posedge clk) begin
                if (rst) status[i] <= 1'b0;
                else     status[i] <= (status[i] & ~clr_vec[i]) | cond[i];
            end
        end else if (LEVEL_BITS[i]) begin : g_level
            always_ff @(posedge clk) begin
                if (rst) status[i] <= 1'b0;
                else     status[i] <= cond[i];
            end
        end else begin : g_none
            assign status[i] = 1'b0;
        end
    end

    assert_fault_latch_R9: assert property (@(posedge clk) disable iff (rst)
        mode_fault |=> status[B_FAULT]);
    assert_txlow_hold_R5: assert property (@(posedge clk) disable iff (rst)
        (status[B_TXLOW] && !clr_vec[B_TXLOW]) |=> status[B_TXLOW]);
    assert_rxne_set_R6: assert property (@(posedge clk) disable iff (rst)
        (rx_level != '0) |=> status[B_RXNE]);
    assert_rxne_clr_R6: assert property (@(posedge clk) disable iff (rst)
        (rx_level == '0) |=> !status[B_RXNE]);
endmodule

// File: rtl/spi_irq_out.sv
module spi_irq_out
    import spi_irq_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  irq_vec_t status,
    input  irq_vec_t mask,
    output logic     irq
);
    always_ff @(posedge clk) begin
        if (rst) irq <= 1'b0;
        else     irq <= |(status & mask);
    end

    assert_irq_rise_R10: assert property (@(posedge clk) disable iff (rst)
        ((status & mask) != '0) |=> irq);
    assert_irq_quiet_R10: assert property (@(posedge clk) disable iff (rst)
        ((status & mask) == '0) |=> !irq);
endmodule

// File: rtl/spi_irq_status.sv
module spi_irq_status
    import spi_irq_pkg::*;
#(
    parameter int FIFO_DEPTH = 63,
    parameter int TX_THR_RST = 1,
    parameter int RX_THR_RST = 32,
    parameter int DATA_W     = 32,
    parameter int LVL_W      = $clog2(FIFO_DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [7:0]        addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    input  logic [LVL_W-1:0]  tx_level,
    input  logic [LVL_W-1:0]  rx_level,
    input  logic              mode_fault,
    output logic              irq
);
    localparam int KEEP_W = (NBITS > LVL_W) ? NBITS : LVL_W;

    irq_vec_t         mask, status, clr_vec;
    logic [LVL_W-1:0] tx_thr, rx_thr;
    logic             unused_hi;

    assign unused_hi = ^wdata[DATA_W-1:KEEP_W];
    assign clr_vec   = (wr_en && addr == OFS_STATUS) ? wdata[NBITS-1:0] : '0;

    spi_irq_regs #(.LVL_W(LVL_W), .TX_THR_RST(TX_THR_RST), .RX_THR_RST(RX_THR_RST)) u_regs (
        .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr),
        .wbits(wdata[NBITS-1:0]), .wthr(wdata[LVL_W-1:0]),
        .mask(mask), .tx_thr(tx_thr), .rx_thr(rx_thr)
    );

    spi_irq_stat #(.FIFO_DEPTH(FIFO_DEPTH), .LVL_W(LVL_W)) u_stat (
        .clk(clk), .rst(rst), .clr_vec(clr_vec),
        .tx_level(tx_level), .rx_level(rx_level),
        .tx_thr(tx_thr), .rx_thr(rx_thr),
        .mode_fault(mode_fault), .status(status)
    );

    spi_irq_out u_out (
        .clk(clk), .rst(rst), .status(status), .mask(mask), .irq(irq)
    );

    always_comb begin
        unique case (addr)
            OFS_STATUS: rdata = DATA_W'(status);
            OFS_MASK:   rdata = DATA_W'(mask);
            OFS_TXTHR:  rdata = DATA_W'(tx_thr);
            OFS_RXTHR:  rdata = DATA_W'(rx_thr);
            default:    rdata = '0;
        endcase
    end
endmodule

// File: tb/test_spi_irq_status.sv
module test_spi_irq_status;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [7:0]  addr = 8'h00;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic [5:0]  tx_level = 6'd10;
    logic [5:0]  rx_level = 6'd0;
    logic        mode_fault = 1'b0;
    logic        irq;
    int          errors = 0;
    int          checks = 0;
    bit          done = 1'b0;

    always #5 clk = ~clk;

    spi_irq_status i_spi_irq_status (
        .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr), .wdata(wdata),
        .rdata(rdata), .tx_level(tx_level), .rx_level(rx_level),
        .mode_fault(mode_fault), .irq(irq)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic bus_wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0; wdata = '0;
    endtask

    task automatic rd_chk(input string req, input logic [7:0] a, input logic [31:0] exp);
        addr = a;
        #1;
        chk(req, rdata, exp);
    endtask

    task automatic set_lv(input logic [5:0] t, input logic [5:0] r);
        @(negedge clk);
        tx_level = t; rx_level = r;
        @(negedge clk);
    endtask

    task automatic t_reset;
        rd_chk("R1 status", 8'h04, 32'h00);
        rd_chk("R1 mask", 8'h10, 32'h00);
        rd_chk("R1 txthr", 8'h28, 32'd1);
        rd_chk("R1 rxthr", 8'h2C, 32'd32);
        chk("R1 irq", {31'b0, irq}, 32'd0);
    endtask

    task automatic t_mask;
        bus_wr(8'h08, 32'h14); rd_chk("R2 set", 8'h10, 32'h14);
        bus_wr(8'h08, 32'h02); rd_chk("R2 keep", 8'h10, 32'h16);
        bus_wr(8'h0C, 32'h04); rd_chk("R3 clear", 8'h10, 32'h12);
        bus_wr(8'h10, 32'h7F); rd_chk("R4 readonly", 8'h10, 32'h12);
        bus_wr(8'h0C, 32'h7F); rd_chk("R3 all", 8'h10, 32'h00);
    endtask

    task automatic t_txlow;
        set_lv(6'd0, 6'd0);  rd_chk("R5 empty", 8'h04, 32'h04);
        bus_wr(8'h04, 32'h04); rd_chk("R5 reset while low", 8'h04, 32'h04);
        set_lv(6'd10, 6'd0); rd_chk("R5 sticky", 8'h04, 32'h04);
        bus_wr(8'h04, 32'h04); rd_chk("R5 cleared", 8'h04, 32'h00);
        bus_wr(8'h28, 32'd16); rd_chk("R11 txthr", 8'h28, 32'd16);
        @(negedge clk);      rd_chk("R5 thr16", 8'h04, 32'h04);
        bus_wr(8'h28, 32'd1);
        bus_wr(8'h04, 32'h04); rd_chk("R5 thr1", 8'h04, 32'h00);
    endtask

    task automatic t_rx;
        set_lv(6'd10, 6'd5); rd_chk("R6 not empty", 8'h04, 32'h10);
        bus_wr(8'h04, 32'h10); rd_chk("R6 w1c ignored", 8'h04, 32'h10);
        set_lv(6'd10, 6'd0); rd_chk("R6 drained", 8'h04, 32'h00);
        set_lv(6'd10, 6'd40); rd_chk("R7 above", 8'h04, 32'h30);
        set_lv(6'd10, 6'd0); rd_chk("R7 sticky", 8'h04, 32'h20);
        bus_wr(8'h04, 32'h20); rd_chk("R7 cleared", 8'h04, 32'h00);
        bus_wr(8'h2C, 32'd4); rd_chk("R11 rxthr", 8'h2C, 32'd4);
        set_lv(6'd10, 6'd4); rd_chk("R7 equal", 8'h04, 32'h30);
        set_lv(6'd10, 6'd3); rd_chk("R7 below kept", 8'h04, 32'h30);
        set_lv(6'd10, 6'd0);
        bus_wr(8'h04, 32'h20); rd_chk("R7 clear2", 8'h04, 32'h00);
        bus_wr(8'h2C, 32'd32);
    endtask

    task automatic t_txfull;
        set_lv(6'd63, 6'd0); rd_chk("R8 full", 8'h04, 32'h08);
        set_lv(6'd10, 6'd0); rd_chk("R8 sticky", 8'h04, 32'h08);
        bus_wr(8'h04, 32'h08); rd_chk("R8 cleared", 8'h04, 32'h00);
    endtask

    task automatic t_fault;
        @(negedge clk); mode_fault = 1'b1;
        @(negedge clk); mode_fault = 1'b0;
        rd_chk("R9 latched", 8'h04, 32'h02);
        @(negedge clk); rd_chk("R9 held", 8'h04, 32'h02);
        bus_wr(8'h04, 32'h02); rd_chk("R9 cleared", 8'h04, 32'h00);
        @(negedge clk); mode_fault = 1'b1; wr_en = 1'b1; addr = 8'h04; wdata = 32'h02;
        @(negedge clk); mode_fault = 1'b0; wr_en = 1'b0; wdata = '0;
        rd_chk("R9 set wins", 8'h04, 32'h02);
        bus_wr(8'h04, 32'h02);
        bus_wr(8'h04, 32'h41); rd_chk("R11 reserved", 8'h04, 32'h00);
    endtask

    task automatic t_irq;
        @(negedge clk); mode_fault = 1'b1;
        @(negedge clk); mode_fault = 1'b0;
        @(negedge clk); chk("R10 masked", {31'b0, irq}, 32'd0);
        bus_wr(8'h08, 32'h02); chk("R10 before", {31'b0, irq}, 32'd0);
        @(negedge clk);        chk("R10 raised", {31'b0, irq}, 32'd1);
        bus_wr(8'h04, 32'h02); chk("R10 still", {31'b0, irq}, 32'd1);
        @(negedge clk);        chk("R10 dropped", {31'b0, irq}, 32'd0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_mask();
        t_txlow();
        t_rx();
        t_txfull();
        t_fault();
        t_irq();
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=timeout expected=done");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule